// File: doc/BRIEF.md
# Half-duplex single-wire UART

This block moves bytes between a host and one shared serial wire, in both directions but never at the same time. The host writes a byte through an 8-bit input with an active-low write strobe. It reads a received byte from an 8-bit output, and it frees the buffer with an active-low read strobe. An 8-bit status word reports whether the single byte buffer is occupied and whether a transmission is waiting, a transmission is running, or a reception is running.

On the line side the block produces a serial output and a transmit-enable flag. Outside the block, the output drives the shared wire only while that flag is high. When the flag is low the wire is released and pulled up to the idle level. A 16-bit clocks-per-bit input sets the bit period in system clocks. Each frame is one low start bit, the data bits least significant first, and one high stop bit.

The receiver finds the falling edge of a start bit and samples every bit at mid-period. It does not listen while its own transmitter is busy or has a byte waiting. A byte that is waiting to go out is held back until any reception in progress has ended. The reset input asserts asynchronously and is released on a clock edge inside the block.

Top module: `swu_top`

## Requirements
- R1: While the reset is low, and after it is released until the first activity, the status word reads 0x00, tx_en is low and line_out is high. Status bits 4 to 1 always read 0.
- R2: When wr_n is low at a clock edge and status bit 0 (buffer full) is low, the byte on wr_data is stored. Bit 0 and bit 6 (transmit pending) read high after that edge.
- R3: On the next edge an idle transmitter takes the stored byte. After that edge bits 0 and 6 read low, and bit 7 (transmit running) and tx_en read high. Buffer-full therefore clears within two clocks of the write.
- R4: A transmitted frame is a low start bit, 8 data bits least significant first and one high stop bit, each lasting bit_clks clocks. tx_en stays high for the ten bit periods and then falls, and line_out is high whenever tx_en is low.
- R5: A falling start edge on line_in begins a reception, sampled at mid-bit. Status bit 5 (receive running) is high during the frame. After a high stop bit, bit 5 is low, bit 0 is high and rd_data shows the received byte.
- R6: When rd_n is low at a clock edge while bit 0 is high and bit 6 is low, bit 0 reads low after that edge.
- R7: A low pulse on line_in shorter than half a bit period starts no reception. Bit 5 returns low and no byte is stored.
- R8: line_in is ignored while the transmitter runs. The echo of the block's own frame sets neither bit 5 nor bit 0.
- R9: A write while bit 0 is high is ignored. rd_data keeps the waiting byte and bit 6 stays low.
- R10: A byte written during a reception stays pending (bit 6 high, tx_en low) until the reception ends, and then starts. Transmission and reception are never active together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_clks | input | 16 | Bit period in system clocks |
| wr_data | input | 8 | Byte to transmit |
| wr_n | input | 1 | Active-low write strobe |
| rd_data | output | 8 | Buffered byte |
| rd_n | input | 1 | Active-low read strobe, frees the buffer |
| status | output | 8 | Bit 7 transmit running, 6 transmit pending, 5 receive running, 0 buffer full |
| line_in | input | 1 | Serial line as seen by the block |
| line_out | output | 1 | Serial data driven when tx_en is high |
| tx_en | output | 1 | High while the block drives the line |

## Verification
The bench uses the default widths: 8 data bits and a 16-bit bit-period counter. It programs bit_clks to 16 for most scenarios and to 5 for one transmit and one receive frame. The odd, short period exercises the rounding of the half-bit point and a start-detection delay that is large compared with the bit. The line is looped back through a wired-AND model, so every transmission also shows whether the block rejects its own echo. The bench drives receive frames cycle by cycle, which lets it place a host write in the middle of a reception and a glitch shorter than half a bit.

// File: rtl/swu_pkg.sv
`timescale 1ns/1ps
package swu_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_START, PH_DATA, PH_STOP} phase_t;
endpackage

// File: rtl/swu_tx.sv
`timescale 1ns/1ps
module swu_tx
  import swu_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] period,
  input  logic          start,
  input  logic [DW-1:0] data,
  output logic          busy,
  output logic          txd
);
  localparam int IW = (DW > 1) ? $clog2(DW) : 1;

  phase_t        phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [DW-1:0] shf_q, shf_d;
  logic [CW-1:0] lim;
  logic          last;

  assign lim  = (period == '0) ? CW'(1) : period;
  assign last = (cnt_q == lim - CW'(1));

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    shf_d   = shf_q;
    case (phase_q)
      PH_IDLE: if (start) begin
        phase_d = PH_START;
        cnt_d   = '0;
        idx_d   = '0;
        shf_d   = data;
      end
      PH_START: if (last) begin
        phase_d = PH_DATA;
        cnt_d   = '0;
      end else cnt_d = cnt_q + CW'(1);
      PH_DATA: if (last) begin
        cnt_d = '0;
        shf_d = shf_q >> 1;
        if (idx_q == IW'(DW - 1)) phase_d = PH_STOP;
        else idx_d = idx_q + IW'(1);
      end else cnt_d = cnt_q + CW'(1);
      PH_STOP: if (last) phase_d = PH_IDLE;
               else cnt_d = cnt_q + CW'(1);
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      shf_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      shf_q   <= shf_d;
    end
  end

  assign busy = (phase_q != PH_IDLE);
  assign txd  = (phase_q == PH_START) ? 1'b0 :
                (phase_q == PH_DATA)  ? shf_q[0] : 1'b1;

  // R4: a frame opens with the low start bit
  p_frame_opens_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd);
  // R3: the top only starts an idle transmitter
  p_start_when_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
endmodule

// File: rtl/swu_rx.sv
`timescale 1ns/1ps
module swu_rx
  import swu_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] period,
  input  logic          rxd,
  input  logic          block,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rx_byte
);
  localparam int IW = (DW > 1) ? $clog2(DW) : 1;

  phase_t        phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [DW-1:0] shf_q, shf_d;
  logic          done_q, done_d;
  logic [CW-1:0] lim;
  logic          last, mid;

  assign lim  = (period == '0) ? CW'(1) : period;
  assign last = (cnt_q == lim - CW'(1));
  assign mid  = (cnt_q == (lim >> 1));

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    shf_d   = shf_q;
    done_d  = 1'b0;
    case (phase_q)
      PH_IDLE: if (!block && !rxd) begin
        phase_d = PH_START;
        cnt_d   = '0;
      end
      PH_START: if (mid) begin
        cnt_d   = '0;
        idx_d   = '0;
        phase_d = rxd ? PH_IDLE : PH_DATA;
      end else cnt_d = cnt_q + CW'(1);
      PH_DATA: if (last) begin
        cnt_d = '0;
        shf_d = {rxd, shf_q[DW-1:1]};
        if (idx_q == IW'(DW - 1)) phase_d = PH_STOP;
        else idx_d = idx_q + IW'(1);
      end else cnt_d = cnt_q + CW'(1);
      PH_STOP: if (last) begin
        phase_d = PH_IDLE;
        done_d  = rxd;
      end else cnt_d = cnt_q + CW'(1);
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      shf_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      shf_q   <= shf_d;
      done_q  <= done_d;
    end
  end

  assign busy    = (phase_q != PH_IDLE);
  assign done    = done_q;
  assign rx_byte = shf_q;

  // R8: a blocked receiver never leaves idle
  p_blocked_stays_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (block && !busy) |=> !busy);
  // R5: a completed byte ends the reception
  p_done_ends_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: rtl/swu_top.sv
`timescale 1ns/1ps
module swu_top #(
  parameter int DW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] bit_clks,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_n,
  output logic [DW-1:0] rd_data,
  input  logic          rd_n,
  output logic [7:0]    status,
  input  logic          line_in,
  output logic          line_out,
  output logic          tx_en
);
  logic          rst_m, rst_q;
  logic          rx_meta, rx_sync;
  logic [DW-1:0] buf_q, buf_d;
  logic          full_q, full_d, pend_q, pend_d, buf_en;
  logic          tx_busy, rx_busy, rx_done, tx_start, rx_block;
  logic          wr_ok, rd_ok;
  logic [DW-1:0] rx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_q <= rst_m;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      rx_meta <= 1'b1;
      rx_sync <= 1'b1;
    end else begin
      rx_meta <= line_in;
      rx_sync <= rx_meta;
    end
  end

  assign wr_ok    = !wr_n && !full_q;
  assign rd_ok    = !rd_n && full_q && !pend_q;
  assign tx_start = pend_q && !tx_busy && !rx_busy;
  assign rx_block = tx_busy || pend_q;

  always_comb begin
    buf_d  = buf_q;
    buf_en = 1'b0;
    full_d = full_q;
    pend_d = pend_q;
    if (wr_ok) begin
      buf_d  = wr_data;
      buf_en = 1'b1;
      full_d = 1'b1;
      pend_d = 1'b1;
    end else if (tx_start) begin
      full_d = 1'b0;
      pend_d = 1'b0;
    end else if (rd_ok) begin
      full_d = 1'b0;
    end else if (rx_done && !full_q) begin
      buf_d  = rx_byte;
      buf_en = 1'b1;
      full_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      buf_q  <= '0;
      full_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (buf_en) buf_q <= buf_d;
      full_q <= full_d;
      pend_q <= pend_d;
    end
  end

  swu_tx #(.DW(DW), .CW(CW)) i_tx (
    .clk(clk), .rst_n(rst_q), .period(bit_clks), .start(tx_start),
    .data(buf_q), .busy(tx_busy), .txd(line_out)
  );

  swu_rx #(.DW(DW), .CW(CW)) i_rx (
    .clk(clk), .rst_n(rst_q), .period(bit_clks), .rxd(rx_sync),
    .block(rx_block), .busy(rx_busy), .done(rx_done), .rx_byte(rx_byte)
  );

  assign tx_en   = tx_busy;
  assign rd_data = buf_q;
  assign status  = {tx_busy, pend_q, rx_busy, 4'b0000, full_q};

  // R2: an accepted write fills the buffer and marks it pending
  p_write_fills_r2: assert property (@(posedge clk) disable iff (!rst_q)
    wr_ok |=> (full_q && pend_q));
  // R3: the transmitter takes the byte and frees the buffer
  p_take_frees_r3: assert property (@(posedge clk) disable iff (!rst_q)
    tx_start |=> (tx_busy && !full_q && !pend_q));
  // R6: a read frees the buffer
  p_read_frees_r6: assert property (@(posedge clk) disable iff (!rst_q)
    rd_ok |=> !full_q);
  // R9: a write into a full buffer leaves the byte alone
  p_write_ignored_r9: assert property (@(posedge clk) disable iff (!rst_q)
    (!wr_n && full_q) |=> $stable(buf_q));
  // R10: the two directions never run together
  p_half_duplex_r10: assert property (@(posedge clk) disable iff (!rst_q)
    !(tx_busy && rx_busy));
  // R10: a pending byte is always held in a full buffer
  p_pend_in_full_r10: assert property (@(posedge clk) disable iff (!rst_q)
    pend_q |-> full_q);
endmodule

// File: tb/test_swu_top.sv
`timescale 1ns/1ps
module test_swu_top;
  logic        clk;
  logic        rst_n;
  logic [15:0] bit_clks;
  logic [7:0]  wr_data;
  logic        wr_n;
  logic [7:0]  rd_data;
  logic        rd_n;
  logic [7:0]  status;
  logic        line_in;
  logic        line_out;
  logic        tx_en;
  logic        drv;
  int          n_chk;
  int          n_fail;
  bit          finished;

  assign line_in = (tx_en ? line_out : 1'b1) & drv;

  swu_top i_swu_top (
    .clk(clk), .rst_n(rst_n), .bit_clks(bit_clks), .wr_data(wr_data),
    .wr_n(wr_n), .rd_data(rd_data), .rd_n(rd_n), .status(status),
    .line_in(line_in), .line_out(line_out), .tx_en(tx_en)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; drv = 1'b1; wr_n = 1'b1; rd_n = 1'b1; wr_data = '0;
    bit_clks = 16'd16;
    tick(3);
    check(status == 8'h00, "R1 status in reset", status, 8'h00);
    check(!tx_en && line_out, "R1 line in reset", {tx_en, line_out}, 2'b01);
    rst_n = 1'b1;
    tick(5);
    check(status == 8'h00, "R1 status after release", status, 8'h00);
    check(!tx_en && line_out, "R1 line after release", {tx_en, line_out}, 2'b01);
  endtask

  task automatic t_transmit(input logic [7:0] b, input int p);
    logic [9:0] fb;
    fb = {1'b1, b, 1'b0};
    bit_clks = 16'(p);
    wr_data = b; wr_n = 1'b0;
    tick(1);
    wr_n = 1'b1;
    check(status[0] && status[6], "R2 full and pending after write", status, 8'h41);
    check(!tx_en, "R2 not yet driving", tx_en, 1'b0);
    tick(1);
    check(!status[0] && !status[6] && status[7], "R3 taken by transmitter", status, 8'h80);
    check(tx_en, "R3 tx_en high", tx_en, 1'b1);
    tick(p / 2);
    for (int i = 0; i < 10; i++) begin
      check(line_out == fb[i], $sformatf("R4 bit %0d", i), line_out, fb[i]);
      check(tx_en, "R4 tx_en through frame", tx_en, 1'b1);
      check(!status[5], "R8 echo not received", status, 8'h80);
      if (i < 9) tick(p);
    end
    tick(p - p / 2);
    check(!tx_en && line_out, "R4 released after stop", {tx_en, line_out}, 2'b01);
    tick(2 * p);
    check(status == 8'h00, "R8 no echoed byte stored", status, 8'h00);
  endtask

  task automatic drive_frame(input logic [7:0] b, input int p, input bit wr_mid,
                             input logic [7:0] wb);
    logic [9:0] fb;
    fb = {1'b1, b, 1'b0};
    for (int c = 0; c < 10 * p; c++) begin
      if (c == 4 * p + p / 2)
        check(status[5], "R5 receive running mid frame", status, 8'h20);
      if (wr_mid && c == 5 * p)
        check(status[6] && !tx_en, "R10 write held pending", {status[6], tx_en}, 2'b10);
      wr_n = !(wr_mid && c == 4 * p + p / 2);
      wr_data = wb;
      drv = fb[c / p];
      tick(1);
    end
    wr_n = 1'b1;
    drv = 1'b1;
  endtask

  task automatic t_receive(input logic [7:0] b, input int p);
    bit_clks = 16'(p);
    drive_frame(b, p, 1'b0, 8'h00);
    tick(4);
    check(status == 8'h01, "R5 byte waiting", status, 8'h01);
    check(rd_data == b, "R5 received byte", rd_data, b);
    rd_n = 1'b0;
    tick(1);
    rd_n = 1'b1;
    check(status == 8'h00, "R6 read frees buffer", status, 8'h00);
  endtask

  task automatic t_write_while_full;
    bit_clks = 16'd16;
    drive_frame(8'h5A, 16, 1'b0, 8'h00);
    tick(4);
    wr_data = 8'h77; wr_n = 1'b0;
    tick(1);
    wr_n = 1'b1;
    tick(2);
    check(rd_data == 8'h5A, "R9 waiting byte kept", rd_data, 8'h5A);
    check(status == 8'h01 && !tx_en, "R9 no pending write", status, 8'h01);
    rd_n = 1'b0;
    tick(1);
    rd_n = 1'b1;
    check(status == 8'h00, "R6 read after ignored write", status, 8'h00);
  endtask

  task automatic t_glitch;
    bit_clks = 16'd16;
    drv = 1'b0;
    tick(2);
    drv = 1'b1;
    tick(24);
    check(status == 8'h00, "R7 short pulse rejected", status, 8'h00);
  endtask

  task automatic t_defer;
    bit_clks = 16'd16;
    drive_frame(8'h96, 16, 1'b1, 8'hC3);
    tick(4);
    check(status[7] && tx_en && !status[6], "R10 starts after reception", status, 8'h80);
    check(!status[5], "R10 never both directions", status, 8'h80);
    tick(11 * 16);
    check(status == 8'h00 && !tx_en, "R10 deferred frame finished", status, 8'h00);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; finished = 1'b0;
    t_reset();
    t_transmit(8'hA5, 16);
    t_transmit(8'h3C, 5);
    t_receive(8'h5A, 16);
    t_receive(8'hC1, 5);
    t_write_while_full();
    t_glitch();
    t_defer();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %h expected %h", 1'b0, 1'b1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule